// File: doc/BRIEF.md
# Programmable Countdown Timer Channel

This block is a single countdown timer channel behind a small write/read register window. Software programs a control word that carries a run flag, a repeat flag and a 29-bit terminal count. The counter steps down only on cycles where the external tick-enable input is high. When it is zero and a tick arrives, the channel raises a sticky interrupt. It then either stops, or reloads the programmed count and keeps running.

The count uses an "N plus one" scheme: a programmed value N expires on the (N+1)-th tick, so a value of zero expires on the first tick. A second register clears the interrupt with a write-one-to-clear bit. The same register reads back the pending flag and the live count. The block is meant to be dropped behind a bus bridge, with the tick generated elsewhere.

Top module: `cdtimer`

## Requirements
- R1: After reset the channel is stopped, `irq` is low, and both readable registers return zero.
- R2: A write at offset 0x0 sets the run flag from bit 31, the repeat flag from bit 30 and the terminal count from bits 28:0. Reading offset 0x0 returns run in bit 31, repeat in bit 30 and the count in bits 28:0, with other bits zero.
- R3: With a terminal count N loaded and running, `irq` stays low after N ticks and becomes high right after the clock edge of tick N+1.
- R4: The live count changes only on cycles with `tickEn` high, or on a write at offset 0x0.
- R5: In non-repeat mode, expiry clears the run flag. The live count then stays at zero, and further ticks have no effect.
- R6: In repeat mode, expiry reloads the terminal count and the channel stays running. It expires again every N+1 ticks with no further write.
- R7: `irq` stays high until a write at offset 0x4 with bit 30 set. A write at offset 0x4 with bit 30 clear leaves it high.
- R8: When an expiry and a clearing write at offset 0x4 occur in the same cycle, `irq` stays high.
- R9: Writing all zeros at offset 0x0 stops the channel. No later tick then raises `irq`.
- R10: A write at offset 0x0 while the channel is running restarts the countdown from the new value.
- R11: Reading offset 0x4 returns the pending flag in bit 30 and the live count in bits 28:0, with other bits zero.
- R12: The largest count 0x1FFFFFFF is loadable, and bit 29 of a control write is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | AW | Byte offset of the write |
| wrData | input | 32 | Write data |
| tickEn | input | 1 | Count tick, one per high cycle |
| rdAddr | input | AW | Byte offset of the read |
| rdData | output | 32 | Read data, combinational |
| irq | output | 1 | Sticky expiry interrupt |

## Verification
A wrong live count shows at once in the low bits of the status read. On the `irq` line it shows as an expiry one or more ticks early or late. A stuck or wrongly cleared run flag shows in bit 31 of the control read on the cycle after expiry. A missed reload shows at the next expiry, which arrives at the wrong tick or never comes. A wrong priority between clear and expiry shows on `irq` one cycle after the colliding edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CTRL_OFS = 0;
  localparam int STAT_OFS = 4;
  localparam int RUN_BIT  = 31;
  localparam int REP_BIT  = 30;
  localparam int CLR_BIT  = 30;

  typedef struct packed {
    logic loadPreset;
    logic clearIrq;
    logic step;
    logic reload;
    logic expire;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [31:0]   wrData,
  input  logic          tickEn,
  input  logic          cntZero,
  output tmrStrobe_t    stb,
  output logic          running,
  output logic          periodic,
  output logic          irqPend
);
  logic wrPreset, wrClear, active;

  always_comb begin
    wrPreset       = wrEn && (wrAddr == AW'(CTRL_OFS));
    wrClear        = wrEn && (wrAddr == AW'(STAT_OFS)) && wrData[CLR_BIT];
    active         = running && tickEn && !wrPreset;
    stb.loadPreset = wrPreset;
    stb.expire     = active && cntZero;
    stb.reload     = active && cntZero && periodic;
    stb.step       = active && !cntZero;
    stb.clearIrq   = wrClear && !(active && cntZero);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running  <= 1'b0;
      periodic <= 1'b0;
    end else if (wrPreset) begin
      running  <= wrData[RUN_BIT];
      periodic <= wrData[REP_BIT];
    end else if (stb.expire && !periodic) begin
      running  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             irqPend <= 1'b0;
    else if (stb.expire)   irqPend <= 1'b1;
    else if (stb.clearIrq) irqPend <= 1'b0;
  end
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CW = 29
) (
  input  logic          clk,
  input  logic          rstN,
  input  tmrStrobe_t    stb,
  input  logic [CW-1:0] loadVal,
  output logic [CW-1:0] preset,
  output logic [CW-1:0] count,
  output logic          cntZero
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preset <= '0;
      count  <= '0;
    end else if (stb.loadPreset) begin
      preset <= loadVal;
      count  <= loadVal;
    end else if (stb.reload) begin
      count  <= preset;
    end else if (stb.step) begin
      count  <= count - CW'(1);
    end
  end

  assign cntZero = (count == '0);
endmodule

// File: rtl/cdtimer.sv
module cdtimer
  import tmr_pkg::*;
#(
  parameter int AW = 4,
  parameter int CW = 29
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [31:0]   wrData,
  input  logic          tickEn,
  input  logic [AW-1:0] rdAddr,
  output logic [31:0]   rdData,
  output logic          irq
);
  tmrStrobe_t    stb;
  logic          running, periodic, irqPend, cntZero;
  logic [CW-1:0] preset, count;

  tmr_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .tickEn(tickEn), .cntZero(cntZero), .stb(stb), .running(running),
    .periodic(periodic), .irqPend(irqPend)
  );

  tmr_datapath #(.CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .loadVal(wrData[CW-1:0]),
    .preset(preset), .count(count), .cntZero(cntZero)
  );

  always_comb begin
    rdData = '0;
    if (rdAddr == AW'(CTRL_OFS)) begin
      rdData[CW-1:0]  = preset;
      rdData[RUN_BIT] = running;
      rdData[REP_BIT] = periodic;
    end else if (rdAddr == AW'(STAT_OFS)) begin
      rdData[CW-1:0]  = count;
      rdData[CLR_BIT] = irqPend;
    end
  end

  assign irq = irqPend;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int AW = 4,
  parameter int CW = 29
) (
  input logic          clk,
  input logic          rstN,
  input logic          wrEn,
  input logic [AW-1:0] wrAddr,
  input logic [31:0]   wrData,
  input logic          tickEn,
  input logic          running,
  input logic          periodic,
  input logic          irqPend,
  input logic [CW-1:0] preset,
  input logic [CW-1:0] count
);
  logic wrP, clr, hitZero;
  assign wrP     = wrEn && (wrAddr == AW'(CTRL_OFS));
  assign clr     = wrEn && (wrAddr == AW'(STAT_OFS)) && wrData[CLR_BIT];
  assign hitZero = running && tickEn && (count == '0) && !wrP;

  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rstN)
    hitZero && !periodic |=> !running && irqPend); // R5
  AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    hitZero && periodic |=> running && (count == $past(preset))); // R6
  AST_TICK_GATE: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn && !wrP |=> $stable(count)); // R4
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    irqPend && !clr |=> irqPend); // R7
  AST_EXPIRY_WINS: assert property (@(posedge clk) disable iff (!rstN)
    hitZero && clr |=> irqPend); // R8
  AST_STOP_ON_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    wrP && (wrData == 32'd0) |=> !running); // R9
  AST_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    wrP |=> count == $past(wrData[CW-1:0])); // R10
endmodule

bind cdtimer tmr_checker #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .tickEn(tickEn), .running(running), .periodic(periodic),
  .irqPend(irqPend), .preset(preset), .count(count)
);

// File: tb/cdtimer_tb.sv
module cdtimer_tb;
  localparam int AW = 4;
  localparam int NV = 6;
  localparam logic [31:0] CLRW = 32'h4000_0000;

  localparam logic [31:0] V_WORD [NV] = '{32'h8000_0003, 32'h8000_0003, 32'h8000_0000,
                                          32'hC000_0005, 32'hC000_0002, 32'h0000_0007};
  localparam int          V_TICK [NV] = '{3, 4, 1, 6, 5, 4};
  localparam logic [31:0] V_STAT [NV] = '{32'h0000_0000, 32'h4000_0000, 32'h4000_0000,
                                          32'h4000_0005, 32'h4000_0000, 32'h0000_0007};

  logic          clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, tickEn = 1'b0;
  logic [AW-1:0] wrAddr = '0, rdAddr = '0;
  logic [31:0]   wrData = '0, rdData;
  logic          irq;
  int            checks = 0, errors = 0;
  bit            done = 1'b0;

  cdtimer u_dut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
                 .tickEn(tickEn), .rdAddr(rdAddr), .rdData(rdData), .irq(irq));

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tickEn = 1'b1;
      @(negedge clk);
      tickEn = 1'b0;
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    rdAddr = a;
    #1 d = rdData;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    rd(4'h0, v); check("R1 ctrl", v, 32'd0);
    rd(4'h4, v); check("R1 stat", v, 32'd0);

    // table walk: R3 R5 R6 R11
    for (int k = 0; k < NV; k++) begin
      wr(4'h4, CLRW);
      wr(4'h0, V_WORD[k]);
      ticks(V_TICK[k]);
      rd(4'h4, v); check($sformatf("R3/R11 vector %0d", k), v, V_STAT[k]);
    end

    // R2 readback, R12 max value and bit 29 ignored
    wr(4'h0, 32'hC000_0123);
    rd(4'h0, v); check("R2 ctrl readback", v, 32'hC000_0123);
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, v); check("R12 ctrl max", v, 32'hDFFF_FFFF);
    rd(4'h4, v); check("R12 count max", v & 32'h1FFF_FFFF, 32'h1FFF_FFFF);

    // R4 no ticks, no change
    wr(4'h0, 32'h8000_0004);
    repeat (5) @(negedge clk);
    rd(4'h4, v); check("R4 count held", v & 32'h1FFF_FFFF, 32'd4);

    // R3 and R5 one-shot exact expiry
    wr(4'h4, CLRW);
    ticks(4);
    check("R3 no early irq", {31'd0, irq}, 32'd0);
    ticks(1);
    check("R3 irq at N+1", {31'd0, irq}, 32'd1);
    rd(4'h0, v); check("R5 run cleared", v, 32'h0000_0004);
    ticks(3);
    rd(4'h4, v); check("R5 stays at zero", v, 32'h4000_0000);

    // R7 sticky and write-one-to-clear
    wr(4'h4, 32'h0000_0000);
    check("R7 zero write keeps irq", {31'd0, irq}, 32'd1);
    wr(4'h4, CLRW);
    check("R7 clear", {31'd0, irq}, 32'd0);

    // R6 periodic refire without rewrite
    wr(4'h0, 32'hC000_0001);
    ticks(2);
    check("R6 first expiry", {31'd0, irq}, 32'd1);
    wr(4'h4, CLRW);
    ticks(1);
    check("R6 no early second", {31'd0, irq}, 32'd0);
    ticks(1);
    check("R6 second expiry", {31'd0, irq}, 32'd1);
    rd(4'h0, v); check("R6 still running", v, 32'hC000_0001);

    // R8 expiry beats clear
    wr(4'h4, CLRW);
    wr(4'h0, 32'h8000_0000);
    tickEn = 1'b1; wrEn = 1'b1; wrAddr = 4'h4; wrData = CLRW;
    @(negedge clk);
    tickEn = 1'b0; wrEn = 1'b0; wrData = '0;
    check("R8 expiry wins", {31'd0, irq}, 32'd1);

    // R9 zero write stops
    wr(4'h4, CLRW);
    wr(4'h0, 32'hC000_0002);
    ticks(1);
    wr(4'h0, 32'h0000_0000);
    rd(4'h0, v); check("R9 stopped", v, 32'd0);
    ticks(5);
    check("R9 no irq", {31'd0, irq}, 32'd0);

    // R10 restart on rewrite
    wr(4'h0, 32'h8000_0009);
    ticks(3);
    rd(4'h4, v); check("R10 before rewrite", v, 32'd6);
    wr(4'h0, 32'h8000_0002);
    ticks(2);
    rd(4'h4, v); check("R10 counted from new", v, 32'd0);
    ticks(1);
    check("R10 expiry", {31'd0, irq}, 32'd1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule